// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the hardware state machine that moves the chip between four clocking modes. In full-speed run, the core runs from the main PLL. In the crystal mode, that PLL is bypassed and the core and bus run from the main crystal. The doze mode is like the crystal mode, but the core clock can be taken from the 32 kHz oscillator. In sleep, the PLLs are stopped. The block drives the PLL power-down and bypass controls, a one-hot core clock-mux select and the per-peripheral kernel clock enables. It also reports the current mode and grants supply-voltage changes, but only while in sleep.

Software asks for a mode by pulsing `req_valid` with a mode code. Any way back into run first powers the PLLs and waits for their lock to stay stable for a programmable number of reference cycles. During that wait the core stays on the bypass clock. Every change of the clock select passes through a period in which no source is selected. A wake event in doze or sleep returns the sequencer to the mode it left when it first went down.

Top module: `pms_power_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `cur_mode` reads 1 (crystal mode), `pll1_bypass` is 1, both PLL power-downs are 0, `clk_sel` is 0, all peripheral enables are 0 and `vchg_grant` is 0. The block then qualifies lock and enters run as in R6.
- R2: In run (mode code 0), `clk_sel` settles to 3'b001 (bit 0 = PLL, bit 1 = crystal, bit 2 = 32 kHz). `pll1_bypass` is 0, both PLLs are powered, `periph_clk_en` equals `periph_mask`, and the PLL is never selected while bypassed.
- R3: In crystal mode (code 1), `clk_sel` settles to 3'b010 and `pll1_bypass` is 1. `pll1_pd` follows `cfg_pll1_off`, `pll2_pd` is 0 and `periph_clk_en` equals `periph_mask`. `pll1_pd` is never 1 while `clk_sel[0]` is 1.
- R4: In doze (code 2), the PLL controls and peripheral enables are as in crystal mode. `clk_sel` settles to 3'b100 when `cfg_doze_lf` is 1 and to 3'b010 when it is 0, and it follows a change of `cfg_doze_lf` made while in doze.
- R5: In sleep (code 3), `clk_sel` settles to 3'b100, `pll1_pd` is 1, `pll2_pd` equals the inverse of `cfg_keep_pll2`, and all peripheral enables are 0.
- R6: On any entry to run, `pll1_pd` drops to 0 and `cur_mode` keeps reporting the mode being left. Let N be `lock_cycles` and let k be the first edge at which both lock inputs have been high for N consecutive edges. `pll1_bypass` falls at edge k+2. A low lock cycle restarts the count.
- R7: `clk_sel` has at most one bit set. It never changes directly from one nonzero value to another. Between two selected sources it stays all-zero for at least SW_GAP+1 cycles.
- R8: A `wake` pulse in doze or sleep returns the block to the mode that was active before the first entry into doze or sleep: run (through relock) or crystal mode. Moving between doze and sleep keeps that return mode. A `wake` pulse in run or crystal mode has no effect.
- R9: `vchg_grant` is 1 exactly one cycle after a cycle in which `vchg_req` is high while the sequencer is in sleep. Otherwise it is 0.
- R10: A request made while the PLLs are relocking, or while the clock switch has not settled, is ignored and not kept for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 2 | Requested mode: 0 run, 1 crystal, 2 doze, 3 sleep |
| cfg_pll1_off | input | 1 | Power down main PLL in crystal and doze modes |
| cfg_doze_lf | input | 1 | Doze core clock from 32 kHz (1) or crystal (0) |
| cfg_keep_pll2 | input | 1 | Keep second PLL running in sleep |
| periph_mask | input | NPERIPH | Per-peripheral kernel clock enable mask |
| lock_cycles | input | CNT_W | Stable-lock cycles required before run |
| pll1_lock | input | 1 | Main PLL lock indication |
| pll2_lock | input | 1 | Second PLL lock indication |
| wake | input | 1 | Wake event |
| vchg_req | input | 1 | Supply-voltage change request |
| pll1_pd | output | 1 | Main PLL power-down |
| pll1_bypass | output | 1 | Main PLL bypass |
| pll2_pd | output | 1 | Second PLL power-down |
| clk_sel | output | 3 | One-hot core clock select (PLL, crystal, 32 kHz) |
| periph_clk_en | output | NPERIPH | Peripheral kernel clock enables |
| cur_mode | output | 2 | Current mode readback |
| vchg_grant | output | 1 | Voltage change permitted |

## Verification
The bench builds the block with NPERIPH=4, CNT_W=6 and SW_GAP=2, and drives `lock_cycles` to 5. A five-cycle lock window is longer than the three-cycle lock burst the bench uses to show the count restarting. It is also short enough to check the exact edge on which bypass falls. With a two-cycle gap, the bench can see every clock-select handover, including the minimum all-zero period, within a few cycles. Four peripherals with a mixed mask are enough to tell masked, fully gated and fully open enables apart.

// File: rtl/pms_pkg.sv
`timescale 1ns/1ps
package pms_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLOW   = 3'd1,
    ST_DOZE   = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_RELOCK = 3'd4
  } pms_state_e;

  localparam logic [1:0] MODE_RUN   = 2'd0;
  localparam logic [1:0] MODE_SLOW  = 2'd1;
  localparam logic [1:0] MODE_DOZE  = 2'd2;
  localparam logic [1:0] MODE_SLEEP = 2'd3;

  localparam int unsigned NSRC = 3;
  localparam logic [NSRC-1:0] SRC_PLL  = 3'b001;
  localparam logic [NSRC-1:0] SRC_XTAL = 3'b010;
  localparam logic [NSRC-1:0] SRC_LF   = 3'b100;

  function automatic logic [1:0] mode_of(input pms_state_e s);
    case (s)
      ST_RUN:   mode_of = MODE_RUN;
      ST_DOZE:  mode_of = MODE_DOZE;
      ST_SLEEP: mode_of = MODE_SLEEP;
      default:  mode_of = MODE_SLOW;
    endcase
  endfunction

endpackage

// File: rtl/pms_lock_qual.sv
`timescale 1ns/1ps
module pms_lock_qual #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             lock,
  input  logic [CNT_W-1:0] thresh,
  output logic             ok
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  // Consecutive-lock counter, cleared by any low lock cycle, saturating
  always_comb begin
    if (!en || !lock) begin
      cnt_nxt = '0;
    end else if (cnt_q != {CNT_W{1'b1}}) begin
      cnt_nxt = cnt_q + 1'b1;
    end else begin
      cnt_nxt = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ok    <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      ok    <= en && lock && (cnt_nxt >= thresh);
    end
  end

  AST_QUAL_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    ok |-> ($past(lock) && $past(en))); // R6

endmodule

// File: rtl/pms_clk_switch.sv
`timescale 1ns/1ps
module pms_clk_switch #(
  parameter int unsigned NSRC = 3,
  parameter int unsigned GAP  = 2,
  localparam int unsigned GW  = $clog2(GAP + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] tgt_oh,
  output logic [NSRC-1:0] sel,
  output logic            idle
);

  logic [GW-1:0] gap_q;

  assign idle = (sel == tgt_oh);

  // Break-before-make: drop the old source, wait GAP cycles, then enable the new one
  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= '0;
      gap_q <= '0;
    end else if (sel != tgt_oh) begin
      if (sel != '0) begin
        sel   <= '0;
        gap_q <= '0;
      end else if (gap_q < GW'(GAP)) begin
        gap_q <= gap_q + 1'b1;
      end else begin
        sel   <= tgt_oh;
        gap_q <= '0;
      end
    end
  end

  AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel)); // R7
  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (rst)
    (($past(sel) != '0) && (sel != '0)) |-> (sel == $past(sel))); // R7

endmodule

// File: rtl/pms_ctrl_fsm.sv
`timescale 1ns/1ps
module pms_ctrl_fsm
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       wake,
  input  logic       sw_idle,
  input  logic       lock_ok,
  output pms_state_e state_q,
  output logic [1:0] mode_rb
);

  pms_state_e state_nxt;
  pms_state_e ret_q, ret_nxt;
  logic [1:0] prev_q, prev_nxt;
  logic       low_state;
  logic       high_state;

  assign low_state  = (state_q == ST_DOZE) || (state_q == ST_SLEEP);
  assign high_state = (state_q == ST_RUN)  || (state_q == ST_SLOW);

  always_comb begin
    state_nxt = state_q;
    ret_nxt   = ret_q;
    prev_nxt  = prev_q;
    if (state_q == ST_RELOCK) begin
      if (lock_ok) begin
        state_nxt = ST_RUN;
      end
    end else if (wake && low_state) begin
      if (ret_q == ST_RUN) begin
        state_nxt = ST_RELOCK;
        prev_nxt  = mode_of(state_q);
      end else begin
        state_nxt = ret_q;
      end
    end else if (req_valid && sw_idle && (req_mode != mode_of(state_q))) begin
      case (req_mode)
        MODE_RUN: begin
          state_nxt = ST_RELOCK;
          prev_nxt  = mode_of(state_q);
        end
        MODE_SLOW: state_nxt = ST_SLOW;
        MODE_DOZE: begin
          state_nxt = ST_DOZE;
          if (high_state) ret_nxt = state_q;
        end
        default: begin
          state_nxt = ST_SLEEP;
          if (high_state) ret_nxt = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RELOCK;
      ret_q   <= ST_SLOW;
      prev_q  <= MODE_SLOW;
    end else begin
      state_q <= state_nxt;
      ret_q   <= ret_nxt;
      prev_q  <= prev_nxt;
    end
  end

  assign mode_rb = (state_q == ST_RELOCK) ? prev_q : mode_of(state_q);

  AST_RUN_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_RUN) && ($past(state_q) != ST_RUN)) |-> $past(lock_ok)); // R6
  AST_RELOCK_EXITS_TO_RUN: assert property (@(posedge clk) disable iff (rst)
    (($past(state_q) == ST_RELOCK) && (state_q != ST_RELOCK)) |-> (state_q == ST_RUN)); // R10

endmodule

// File: rtl/pms_power_seq.sv
`timescale 1ns/1ps
module pms_power_seq
  import pms_pkg::*;
#(
  parameter int unsigned NPERIPH = 8,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned SW_GAP  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         req_mode,
  input  logic               cfg_pll1_off,
  input  logic               cfg_doze_lf,
  input  logic               cfg_keep_pll2,
  input  logic [NPERIPH-1:0] periph_mask,
  input  logic [CNT_W-1:0]   lock_cycles,
  input  logic               pll1_lock,
  input  logic               pll2_lock,
  input  logic               wake,
  input  logic               vchg_req,
  output logic               pll1_pd,
  output logic               pll1_bypass,
  output logic               pll2_pd,
  output logic [2:0]         clk_sel,
  output logic [NPERIPH-1:0] periph_clk_en,
  output logic [1:0]         cur_mode,
  output logic               vchg_grant
);

  pms_state_e      state_q;
  logic [1:0]      mode_rb;
  logic            lock_ok;
  logic            sw_idle;
  logic [NSRC-1:0] tgt_oh;
  logic            pd1_raw;
  logic            periph_on;

  pms_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .wake      (wake),
    .sw_idle   (sw_idle),
    .lock_ok   (lock_ok),
    .state_q   (state_q),
    .mode_rb   (mode_rb)
  );

  pms_lock_qual #(.CNT_W(CNT_W)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .en     (state_q == ST_RELOCK),
    .lock   (pll1_lock && pll2_lock),
    .thresh (lock_cycles),
    .ok     (lock_ok)
  );

  pms_clk_switch #(.NSRC(NSRC), .GAP(SW_GAP)) u_sw (
    .clk    (clk),
    .rst    (rst),
    .tgt_oh (tgt_oh),
    .sel    (clk_sel),
    .idle   (sw_idle)
  );

  // Core clock source wanted in each state
  always_comb begin
    case (state_q)
      ST_RUN:   tgt_oh = SRC_PLL;
      ST_DOZE:  tgt_oh = cfg_doze_lf ? SRC_LF : SRC_XTAL;
      ST_SLEEP: tgt_oh = SRC_LF;
      default:  tgt_oh = SRC_XTAL;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_SLEEP:         pd1_raw = 1'b1;
      ST_SLOW, ST_DOZE: pd1_raw = cfg_pll1_off;
      default:          pd1_raw = 1'b0;
    endcase
  end

  assign periph_on = (state_q == ST_RUN) || (state_q == ST_SLOW) || (state_q == ST_DOZE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pll1_pd     <= 1'b0;
      pll1_bypass <= 1'b1;
      pll2_pd     <= 1'b0;
      cur_mode    <= MODE_SLOW;
      vchg_grant  <= 1'b0;
    end else begin
      // power down only once the PLL no longer drives the core
      pll1_pd     <= pd1_raw && !clk_sel[0];
      // enter bypass only after the PLL has been deselected
      pll1_bypass <= (state_q != ST_RUN) && (!clk_sel[0] || pll1_bypass);
      pll2_pd     <= (state_q == ST_SLEEP) && !cfg_keep_pll2;
      cur_mode    <= mode_rb;
      vchg_grant  <= vchg_req && (state_q == ST_SLEEP);
    end
  end

  for (genvar i = 0; i < NPERIPH; i++) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst) begin
        periph_clk_en[i] <= 1'b0;
      end else begin
        periph_clk_en[i] <= periph_on && periph_mask[i];
      end
    end
  end

  AST_PD_CLEAR_OF_SEL: assert property (@(posedge clk) disable iff (rst)
    pll1_pd |-> !clk_sel[0]); // R3
  AST_PLL_SEL_UNBYPASSED: assert property (@(posedge clk) disable iff (rst)
    clk_sel[0] |-> !pll1_bypass); // R2
  AST_GRANT_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
    vchg_grant |-> ($past(vchg_req) && ($past(state_q) == ST_SLEEP))); // R9
  AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_SLEEP) |-> (periph_clk_en == '0)); // R5

endmodule

// File: tb/tb_pms_power_seq.sv
`timescale 1ns/1ps
module tb_pms_power_seq;

  localparam int NP   = 4;
  localparam int CW   = 6;
  localparam int GAP  = 2;
  localparam int NLCK = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [1:0]    req_mode;
  logic          cfg_pll1_off, cfg_doze_lf, cfg_keep_pll2;
  logic [NP-1:0] periph_mask;
  logic [CW-1:0] lock_cycles;
  logic          pll1_lock, pll2_lock, wake, vchg_req;
  logic          pll1_pd, pll1_bypass, pll2_pd;
  logic [2:0]    clk_sel;
  logic [NP-1:0] periph_clk_en;
  logic [1:0]    cur_mode;
  logic          vchg_grant;

  int n_chk = 0;
  int n_fail = 0;
  int glitches = 0;
  int short_gaps = 0;

  always #10 clk = ~clk;

  pms_power_seq #(.NPERIPH(NP), .CNT_W(CW), .SW_GAP(GAP)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .cfg_pll1_off(cfg_pll1_off), .cfg_doze_lf(cfg_doze_lf), .cfg_keep_pll2(cfg_keep_pll2),
    .periph_mask(periph_mask), .lock_cycles(lock_cycles),
    .pll1_lock(pll1_lock), .pll2_lock(pll2_lock), .wake(wake), .vchg_req(vchg_req),
    .pll1_pd(pll1_pd), .pll1_bypass(pll1_bypass), .pll2_pd(pll2_pd), .clk_sel(clk_sel),
    .periph_clk_en(periph_clk_en), .cur_mode(cur_mode), .vchg_grant(vchg_grant)
  );

  // Clock-select handover monitor (R7)
  logic [2:0] mon_prev;
  int         mon_zero;
  bit         mon_seen;
  always @(negedge clk) begin
    if (rst) begin
      mon_prev = '0; mon_zero = 0; mon_seen = 0;
    end else begin
      if (mon_prev != 0 && clk_sel != 0 && clk_sel != mon_prev) glitches++;
      if (clk_sel == 0) mon_zero++;
      else begin
        if (mon_prev == 0 && mon_seen && mon_zero < GAP + 1) short_gaps++;
        mon_zero = 0;
        mon_seen = 1;
      end
      mon_prev = clk_sel;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic request(input logic [1:0] m);
    req_valid = 1'b1; req_mode = m;
    tick(1);
    req_valid = 1'b0;
  endtask

  task automatic settle(input string tag, input logic [2:0] s, input logic [1:0] m);
    for (int i = 0; i < 60; i++) begin
      if (clk_sel == s && cur_mode == m) break;
      tick(1);
    end
    chk({tag, " clk_sel"}, 32'(clk_sel), 32'(s));
    chk({tag, " cur_mode"}, 32'(cur_mode), 32'(m));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    tick(3);
    chk("R1 mode", 32'(cur_mode), 1);
    chk("R1 bypass", 32'(pll1_bypass), 1);
    chk("R1 pds", 32'({pll1_pd, pll2_pd}), 0);
    chk("R1 sel", 32'(clk_sel), 0);
    chk("R1 periph", 32'(periph_clk_en), 0);
    chk("R1 grant", 32'(vchg_grant), 0);
  endtask

  task automatic t_first_run;
    rst = 1'b0;
    tick(4);
    chk("R6 no lock stays", 32'({cur_mode, pll1_bypass}), 32'b011);
    pll1_lock = 1; pll2_lock = 1;
    tick(NLCK + 1);
    chk("R6 bypass before window", 32'(pll1_bypass), 1);
    tick(1);
    chk("R6 bypass at window", 32'(pll1_bypass), 0);
    settle("R2 run", 3'b001, 2'd0);
    chk("R2 pds", 32'({pll1_pd, pll2_pd}), 0);
    chk("R2 periph", 32'(periph_clk_en), 32'(periph_mask));
  endtask

  task automatic t_slow_and_relock;
    cfg_pll1_off = 1;
    request(2'd1);
    settle("R3 slow", 3'b010, 2'd1);
    tick(2);
    chk("R3 pll1_pd", 32'(pll1_pd), 1);
    chk("R3 bypass pll2", 32'({pll1_bypass, pll2_pd}), 32'b10);
    chk("R3 periph", 32'(periph_clk_en), 32'(periph_mask));
    pll1_lock = 0; pll2_lock = 0;
    request(2'd0);
    tick(1);
    chk("R6 pll1 powered on relock", 32'(pll1_pd), 0);
    chk("R6 mode held", 32'(cur_mode), 1);
    pll1_lock = 1; pll2_lock = 1;
    tick(3);
    pll2_lock = 0;
    tick(1);
    pll2_lock = 1;
    tick(NLCK + 1);
    chk("R6 restarted count", 32'(pll1_bypass), 1);
    tick(1);
    chk("R6 restarted bypass off", 32'(pll1_bypass), 0);
    settle("R6 run again", 3'b001, 2'd0);
  endtask

  task automatic t_doze;
    cfg_pll1_off = 0; cfg_doze_lf = 0;
    request(2'd2);
    settle("R4 doze xtal", 3'b010, 2'd2);
    tick(1);
    chk("R4 pd bypass", 32'({pll1_pd, pll1_bypass, pll2_pd}), 32'b010);
    chk("R4 periph", 32'(periph_clk_en), 32'(periph_mask));
    cfg_doze_lf = 1;
    settle("R4 doze lf", 3'b100, 2'd2);
    wake = 1; tick(1); wake = 0;
    settle("R8 wake to run", 3'b001, 2'd0);
  endtask

  task automatic t_sleep_vchg;
    cfg_keep_pll2 = 1; vchg_req = 1;
    tick(2);
    chk("R9 no grant in run", 32'(vchg_grant), 0);
    request(2'd3);
    settle("R5 sleep", 3'b100, 2'd3);
    tick(1);
    chk("R5 pll1 off pll2 kept", 32'({pll1_pd, pll2_pd}), 32'b10);
    chk("R5 periph off", 32'(periph_clk_en), 0);
    chk("R9 grant in sleep", 32'(vchg_grant), 1);
    vchg_req = 0;
    tick(1);
    chk("R9 grant drops", 32'(vchg_grant), 0);
    cfg_keep_pll2 = 0;
    tick(2);
    chk("R5 pll2 off", 32'(pll2_pd), 1);
    pll1_lock = 0; pll2_lock = 0;
    wake = 1; tick(1); wake = 0;
    tick(3);
    chk("R8 relock from sleep", 32'({cur_mode, pll1_bypass, pll1_pd, pll2_pd}), 32'b11100);
    pll1_lock = 1; pll2_lock = 1;
    settle("R8 sleep back to run", 3'b001, 2'd0);
  endtask

  task automatic t_nested_return;
    cfg_doze_lf = 0;
    request(2'd1);
    settle("R8 slow", 3'b010, 2'd1);
    request(2'd2);
    settle("R8 doze", 3'b010, 2'd2);
    request(2'd3);
    settle("R8 sleep", 3'b100, 2'd3);
    wake = 1; tick(1); wake = 0;
    settle("R8 back to slow", 3'b010, 2'd1);
    wake = 1; tick(1); wake = 0;
    tick(6);
    chk("R8 wake ignored in slow", 32'({cur_mode, clk_sel}), 32'({2'd1, 3'b010}));
  endtask

  task automatic t_ignored;
    pll1_lock = 0; pll2_lock = 0;
    request(2'd0);
    request(2'd3);
    tick(3);
    chk("R10 req during relock", 32'({cur_mode, pll1_pd}), 32'b010);
    pll1_lock = 1; pll2_lock = 1;
    settle("R10 ends in run", 3'b001, 2'd0);
    request(2'd1);
    request(2'd2);
    settle("R10 slow", 3'b010, 2'd1);
    tick(10);
    chk("R10 doze dropped", 32'(cur_mode), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1; req_valid = 0; req_mode = 0;
    cfg_pll1_off = 0; cfg_doze_lf = 0; cfg_keep_pll2 = 0;
    periph_mask = 4'b1011; lock_cycles = CW'(NLCK);
    pll1_lock = 0; pll2_lock = 0; wake = 0; vchg_req = 0;
    @(negedge clk);
    t_reset;
    t_first_run;
    t_slow_and_relock;
    t_doze;
    t_sleep_vchg;
    t_nested_return;
    t_ignored;
    chk("R7 direct swaps", 32'(glitches), 0);
    chk("R7 short gaps", 32'(short_gaps), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule